// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block sits beside the fetch program counter and guesses the next fetch address in the same cycle the current address is presented. It is a direct-mapped table indexed by the low word-address bits of the PC. Each slot holds a valid bit, the upper PC bits as a tag, and the destination address the branch at that PC jumped to on its most recent taken execution. When the presented PC matches a valid slot, fetch is steered to the stored destination at once, without waiting for the branch to resolve. When it does not match, the next address is the sequential one, PC plus one word.

A second port is driven when a branch resolves in the back end. A taken outcome fills or overwrites the slot for that branch. A not-taken outcome removes the slot, but only if the slot currently belongs to that same branch. Direction counters, return stacks and recovery sequencing are outside this block.

Top module: `btb_predictor`

## Requirements
- R1: With the default parameters, PC bits [7:2] select one of 64 slots and PC bits [31:8] form the tag. A lookup hits only when the selected slot is valid and its tag equals PC[31:8].
- R2: On a miss, `lk_next_pc` equals `lk_pc + 4` modulo 2^32, so 32'hFFFF_FFFC gives 0.
- R3: After reset every slot is invalid, and every lookup misses.
- R4: On a hit, `lk_next_pc` equals the stored destination with bits [1:0] forced to zero. Bits [1:0] of `up_target` are not kept.
- R5: An update with `up_valid`=1 and `up_taken`=1 writes the tag, the destination and valid=1 into the slot chosen by `up_pc[7:2]`, replacing any other branch that aliases to that slot.
- R6: An update with `up_valid`=1 and `up_taken`=0 clears the slot only when that slot is valid and its tag equals `up_pc[31:8]`. Otherwise the slot keeps its contents.
- R7: While `up_valid`=0, the table does not change, whatever `up_pc`, `up_target` and `up_taken` carry.
- R8: A lookup in the same cycle as an update to the same slot returns the contents from before the update. The new contents are visible from the cycle after the clock edge.
- R9: The lookup is combinational: `lk_hit` and `lk_next_pc` follow `lk_pc` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch address being looked up |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_next_pc | output | 32 | Predicted next fetch address |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | 32 | Address of the resolved branch |
| up_target | input | 32 | Resolved destination address |
| up_taken | input | 1 | Resolved branch was taken |

## Verification
The hardest situations to reach from the ports are those where two branches share a slot, and a lookup and an update hit the same slot in the same cycle. The stimulus fills all 64 slots with distinct tags. It then writes an aliasing tag over one slot and sends not-taken updates whose tag matches, and whose tag does not, to neighbouring slots. To check the same-cycle case, it presents a lookup and an update to one slot together and samples before and after the edge. Expected results come from a small bench model that applies the requirement rules, not the design's logic.

// File: rtl/btb_pkg.sv
package btb_pkg;
    typedef enum logic [1:0] {
        BTB_KEEP = 2'd0,
        BTB_FILL = 2'd1,
        BTB_DROP = 2'd2
    } btb_act_e;
endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 6,
    parameter int ALIGN_W = 2,
    localparam int TAG_W  = PC_W - IDX_W - ALIGN_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    // word-aligned low bits are dropped, next bits index, the rest tag
    always_comb begin
        idx = pc[ALIGN_W +: IDX_W];
        tag = pc[PC_W-1 -: TAG_W];
    end
endmodule

// File: rtl/btb_upd_ctrl.sv
module btb_upd_ctrl
    import btb_pkg::*;
(
    input  logic     up_valid,
    input  logic     up_taken,
    input  logic     slot_match,
    output btb_act_e act
);
    always_comb begin
        act = BTB_KEEP;
        if (up_valid) begin
            if (up_taken)        act = BTB_FILL;
            else if (slot_match) act = BTB_DROP;
        end
    end
endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 24,
    parameter int TGT_W   = 30,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt,
    input  logic [IDX_W-1:0] chk_idx,
    output logic             chk_valid,
    output logic [TAG_W-1:0] chk_tag,
    input  btb_act_e         act,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt
);
    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][TGT_W-1:0] tgt;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        case (act)
            BTB_FILL: begin
                tbl_d.valid[chk_idx] = 1'b1;
                tbl_d.tag[chk_idx]   = wr_tag;
                tbl_d.tgt[chk_idx]   = wr_tgt;
            end
            BTB_DROP: tbl_d.valid[chk_idx] = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    // reads see registered contents only: same-cycle write is invisible
    always_comb begin
        rd_valid  = tbl_q.valid[rd_idx];
        rd_tag    = tbl_q.tag[rd_idx];
        rd_tgt    = tbl_q.tgt[rd_idx];
        chk_valid = tbl_q.valid[chk_idx];
        chk_tag   = tbl_q.tag[chk_idx];
    end

    a_r5_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
        act == BTB_FILL |=> tbl_q.valid[$past(chk_idx)] && tbl_q.tgt[$past(chk_idx)] == $past(wr_tgt));
    a_r6_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        act == BTB_DROP |=> !tbl_q.valid[$past(chk_idx)]);
    a_r7_keep_stable: assert property (@(posedge clk) disable iff (!rst_n)
        act == BTB_KEEP |=> $stable(tbl_q.valid));
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64,
    parameter int ALIGN_W = 2,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IDX_W - ALIGN_W,
    localparam int TGT_W  = PC_W - ALIGN_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic [PC_W-1:0] up_target,
    input  logic            up_taken
);
    localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN_W;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             rd_valid, chk_valid;
    logic [TAG_W-1:0] rd_tag, chk_tag;
    logic [TGT_W-1:0] rd_tgt;
    logic             up_match;
    btb_act_e         act;

    btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) i_split_lk (
        .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
    );
    btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) i_split_up (
        .pc(up_pc), .idx(up_idx), .tag(up_tag)
    );

    btb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .TGT_W(TGT_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
        .chk_idx(up_idx), .chk_valid(chk_valid), .chk_tag(chk_tag),
        .act(act), .wr_tag(up_tag), .wr_tgt(up_target[PC_W-1:ALIGN_W])
    );

    always_comb up_match = chk_valid && (chk_tag == up_tag);

    btb_upd_ctrl i_ctrl (
        .up_valid(up_valid), .up_taken(up_taken), .slot_match(up_match), .act(act)
    );

    always_comb begin
        lk_hit     = rd_valid && (rd_tag == lk_tag);
        lk_next_pc = lk_hit ? {rd_tgt, {ALIGN_W{1'b0}}} : lk_pc + STEP;
    end

    a_r3_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !lk_hit);
    a_r4_hit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_next_pc[ALIGN_W-1:0] == '0);
    a_r5_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_taken |=> (lk_pc != $past(up_pc)) ||
            (lk_hit && lk_next_pc[PC_W-1:ALIGN_W] == $past(up_target[PC_W-1:ALIGN_W])));
    a_r6_drop_visible: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && !up_taken && up_match |=> (lk_pc != $past(up_pc)) || !lk_hit);
endmodule

// File: tb/test_btb_predictor.sv
module test_btb_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit;
    logic [31:0] lk_next_pc;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic [31:0] up_target = '0;
    logic        up_taken = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bit          m_v   [64];
    logic [23:0] m_tag [64];
    logic [29:0] m_tgt [64];

    always #4 clk = ~clk;

    btb_predictor i_btb_predictor (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_next_pc(lk_next_pc),
        .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target), .up_taken(up_taken)
    );

    function automatic logic [31:0] mk_pc(input int slot, input int salt);
        logic [23:0] t = 24'h3C_0000 + 24'(slot * 13 + salt * 977);
        return {t, 6'(slot), 2'b00};
    endfunction

    function automatic logic [31:0] mk_tgt(input int slot, input int salt);
        return 32'h1000_0003 + 32'(slot) * 32'h0004_0104 + 32'(salt) * 32'h0111_0000;
    endfunction

    task automatic check(input logic [31:0] pc, input string rq);
        int          s = int'(pc[7:2]);
        logic        eh;
        logic [31:0] en;
        lk_pc = pc;
        #1;
        eh = m_v[s] && (m_tag[s] == pc[31:8]);
        en = eh ? {m_tgt[s], 2'b00} : pc + 32'd4;
        n_tests++;
        if (lk_hit !== eh || lk_next_pc !== en) begin
            n_fail++;
            $display("FAIL %s pc=%h: hit=%b next=%h expected hit=%b next=%h",
                     rq, pc, lk_hit, lk_next_pc, eh, en);
        end
    endtask

    task automatic model_upd(input logic [31:0] pc, input logic [31:0] tg, input logic tk);
        int s = int'(pc[7:2]);
        if (tk) begin
            m_v[s] = 1'b1; m_tag[s] = pc[31:8]; m_tgt[s] = tg[31:2];
        end else if (m_v[s] && m_tag[s] == pc[31:8]) begin
            m_v[s] = 1'b0;
        end
    endtask

    task automatic upd(input logic [31:0] pc, input logic [31:0] tg, input logic tk, input logic vl);
        @(negedge clk);
        up_valid = vl; up_pc = pc; up_target = tg; up_taken = tk;
        @(posedge clk);
        if (vl) model_upd(pc, tg, tk);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R2: every slot misses after reset, sequential next address
        for (int i = 0; i < 64; i++) check(mk_pc(i, 0), "R3");
        check(32'hFFFF_FFFC, "R2 wrap");

        // R5 / R4 / R1: fill every slot, targets carry nonzero low bits
        for (int i = 0; i < 64; i++) upd(mk_pc(i, 0), mk_tgt(i, 0), 1'b1, 1'b1);
        @(negedge clk);
        for (int i = 0; i < 64; i++) check(mk_pc(i, 0), "R4 R5");
        // R1: same slot, other tag misses
        for (int i = 0; i < 64; i += 5) check(mk_pc(i, 1), "R1 tag mismatch");
        // R9: lookups change with no clock edge in between
        check(mk_pc(3, 0), "R9"); check(mk_pc(3, 2), "R9"); check(mk_pc(4, 0), "R9");

        // R5 aliasing: overwrite slot 5 with another tag
        upd(mk_pc(5, 1), mk_tgt(5, 1), 1'b1, 1'b1);
        check(mk_pc(5, 0), "R5 alias old");
        check(mk_pc(5, 1), "R5 alias new");

        // R6: not-taken with non-matching tag leaves slot 6
        upd(mk_pc(6, 3), mk_tgt(6, 3), 1'b0, 1'b1);
        check(mk_pc(6, 0), "R6 keep");
        // R6: not-taken matching tag clears slot 7
        upd(mk_pc(7, 0), mk_tgt(7, 0), 1'b0, 1'b1);
        check(mk_pc(7, 0), "R6 clear");
        n_tests++;
        if (lk_hit !== 1'b0) begin
            n_fail++; $display("FAIL R6 slot 7 hit=%b expected 0", lk_hit);
        end

        // R7: strobe low, every other field active
        upd(mk_pc(8, 4), mk_tgt(8, 4), 1'b1, 1'b0);
        check(mk_pc(8, 0), "R7 old kept");
        check(mk_pc(8, 4), "R7 no fill");
        upd(mk_pc(9, 0), mk_tgt(9, 0), 1'b0, 1'b0);
        check(mk_pc(9, 0), "R7 no drop");

        // R8: same-cycle lookup and update on slot 10
        @(negedge clk);
        up_valid = 1'b1; up_pc = mk_pc(10, 2); up_target = mk_tgt(10, 2); up_taken = 1'b1;
        check(mk_pc(10, 2), "R8 before edge");
        check(mk_pc(10, 0), "R8 before edge old");
        @(posedge clk);
        model_upd(mk_pc(10, 2), mk_tgt(10, 2), 1'b1);
        @(negedge clk);
        up_valid = 1'b0;
        check(mk_pc(10, 2), "R8 after edge");
        n_tests++;
        if (lk_hit !== 1'b1) begin
            n_fail++; $display("FAIL R8 hit=%b expected 1", lk_hit);
        end

        // R2 wrap on a miss, full sweep again
        check(32'hFFFF_FFFC, "R2 wrap");
        for (int i = 0; i < 64; i++) check(mk_pc(i, 0), "R1 sweep");

        // R3: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
        for (int i = 0; i < 64; i++) check(mk_pc(i, 0), "R3 re-reset");

        finish_run();
    end
endmodule